// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of one 16-bit, four-bank SDRAM from reset until the memory can take normal traffic. First it holds a long quiet pause, with clock enable and the data masks high and only no-operation commands on the bus. It then runs a fixed, timed series of commands: one precharge of every bank, a load of the mode register, and eight auto-refresh commands. Each command is followed by at least the minimum gap the memory needs. After the last gap it raises a ready flag. The mode-register value comes from an input port and is copied onto the address pins only in the load cycle.

The state machine moves through these states. `ST_PAUSE` leaves on pause-timer expiry (`pause_done`) to `ST_PRECHARGE`. That state always steps (`pre_issued`) to `ST_WAIT_RP`. When the row-precharge gap ends (`rp_done`) it goes to `ST_LOAD_MODE`. That state always steps (`mode_issued`) to `ST_WAIT_RSC`. When the mode-set gap ends (`rsc_done`) it goes to `ST_REFRESH`. That state always steps (`ref_issued`) to `ST_WAIT_RC`. When the refresh gap ends, the machine goes back to `ST_REFRESH` (`ref_again`) while fewer than eight refreshes have gone out, or on to `ST_READY` (`ref_all_done`). `ST_READY` is held until reset. Reset puts the machine back in `ST_PAUSE` from any state.

Gaps are parameters in clock cycles, written here as P (pause, = CLK_MHZ × PAUSE_US), TRP, TRSC and TRC. Each of TRP, TRSC and TRC must be at least 2. Cycle 0 is the clock period right after reset is released, and cycle k follows the k-th rising edge after release.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high the bus carries NOP, clock enable is low, both mask bits are high, bank and address are zero and ready is low.
- R2: From cycle 0 to cycle P-1 only NOP is driven, with both mask bits high; clock enable is high from cycle 1 on and stays high.
- R3: In cycle P a precharge-all is driven: chip select, row strobe and write enable low, column strobe high, address bit 10 high, every other address bit and the bank bits zero.
- R4: In cycle P+TRP a mode-register load is driven: all four command pins low, bank bits zero, address equal to the mode input in that cycle. The mode input has no effect on the address in any other cycle.
- R5: Exactly eight auto-refresh commands are driven (chip select, row and column strobe low, write enable high), the first in cycle P+TRP+TRSC and each next one TRC cycles after the previous.
- R6: In every cycle after reset that is not one of the commands above, the bus carries NOP (chip select low, other three strobes high) with bank and address zero.
- R7: Ready rises in cycle P+TRP+TRSC+8·TRC, stays high until reset, and both mask bits drop low together with it; before that cycle ready is low.
- R8: A reset applied at any point in the sequence restarts it from the pause, with the same cycle timing as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_word | input | ADDR_W | Value written into the mode register |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Byte data masks |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Memory ready for normal traffic |

## Verification
Each full sequence is checked cycle by cycle against a command schedule worked out from the gap parameters. A mismatch in any single gap therefore shows up as a command in the wrong cycle, not only as a late ready. The mode input is changed on every cycle, and the target value is present only in the load cycle. This separates a design that samples the mode in the right cycle from one that leaks it onto the bus or latches it early. Two different mode values are used. One run is aborted by a reset in the middle of the refresh train and then rerun in full, which shows whether the refresh count and timers really return to their start values.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_LOAD_MODE,
        CMD_REFRESH
    } sdi_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_LOAD_MODE,
        ST_WAIT_RSC,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_READY
    } sdi_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdi_pins_t;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= W'(RST_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

    // R2/R5 support: a loaded gap appears in the counter on the next cycle
    p_load_takes_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_q == $past(load_val)));

    // R2 support: the counter never wraps below zero
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
(
    input  sdi_cmd_e  cmd,
    output sdi_pins_t pins
);
    always_comb begin
        unique case (cmd)
            CMD_NOP:       pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRECHARGE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_LOAD_MODE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            CMD_REFRESH:   pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default:       pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int PAUSE_US = 200,
    parameter int TRP      = 3,
    parameter int TRSC     = 2,
    parameter int TRC      = 7,
    parameter int NREF     = 8,
    parameter int ADDR_W   = 12,
    parameter int BA_W     = 2,
    parameter int DQM_W    = 2,
    parameter int AP_BIT   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int GAP_MAX   = (TRP > TRSC) ? ((TRP > TRC) ? TRP : TRC)
                                            : ((TRSC > TRC) ? TRSC : TRC);
    localparam int CNT_MAX   = (PAUSE_CYC > GAP_MAX) ? PAUSE_CYC : GAP_MAX;
    localparam int TW        = $clog2(CNT_MAX + 1);
    localparam int RW        = $clog2(NREF + 1);

    sdi_state_e     state_q, state_d;
    logic [RW-1:0]  ref_cnt_q;
    logic           cke_q;
    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_done;
    sdi_cmd_e       cmd;
    sdi_pins_t      pins;

    sdram_init_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sdram_init_cmd_enc u_enc (
        .cmd  (cmd),
        .pins (pins)
    );

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PAUSE:     if (tmr_done) state_d = ST_PRECHARGE;
            ST_PRECHARGE: begin
                state_d  = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = TW'(TRP - 2);
            end
            ST_WAIT_RP:   if (tmr_done) state_d = ST_LOAD_MODE;
            ST_LOAD_MODE: begin
                state_d  = ST_WAIT_RSC;
                tmr_load = 1'b1;
                tmr_val  = TW'(TRSC - 2);
            end
            ST_WAIT_RSC:  if (tmr_done) state_d = ST_REFRESH;
            ST_REFRESH: begin
                state_d  = ST_WAIT_RC;
                tmr_load = 1'b1;
                tmr_val  = TW'(TRC - 2);
            end
            ST_WAIT_RC: begin
                if (tmr_done) begin
                    state_d = (ref_cnt_q == RW'(NREF)) ? ST_READY : ST_REFRESH;
                end
            end
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_PAUSE;
        endcase
    end

    // State register, refresh counter, clock enable
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_PAUSE;
            ref_cnt_q <= '0;
            cke_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            cke_q   <= 1'b1;
            if (state_q == ST_REFRESH) ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cmd     = CMD_NOP;
        sd_addr = '0;
        sd_ba   = '0;
        unique case (state_q)
            ST_PRECHARGE: begin
                cmd             = CMD_PRECHARGE;
                sd_addr[AP_BIT] = 1'b1;
            end
            ST_LOAD_MODE: begin
                cmd     = CMD_LOAD_MODE;
                sd_addr = mode_word;
            end
            ST_REFRESH:   cmd = CMD_REFRESH;
            default:      cmd = CMD_NOP;
        endcase
    end

    assign sd_cs_n   = pins.cs_n;
    assign sd_ras_n  = pins.ras_n;
    assign sd_cas_n  = pins.cas_n;
    assign sd_we_n   = pins.we_n;
    assign sd_cke    = cke_q;
    assign init_done = (state_q == ST_READY);
    assign sd_dqm    = {DQM_W{~init_done}};

    // R2: no real command while pausing
    p_nop_in_pause_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAUSE) |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));

    // R4: clock enable high for a cycle before the mode load
    p_cke_before_mode_r4: assert property (@(posedge clk) disable iff (rst)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_cke && $past(sd_cke)));

    // R5: never more refreshes than asked for
    p_ref_bound_r5: assert property (@(posedge clk) disable iff (rst)
        ref_cnt_q <= RW'(NREF));

    // R7: ready is sticky
    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R7: ready only after all refreshes
    p_ready_after_refs_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (ref_cnt_q == RW'(NREF)));

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
    localparam int CLK_P    = 10;
    localparam int CLK_MHZ  = 1;
    localparam int PAUSE_US = 40;
    localparam int TRP      = 3;
    localparam int TRSC     = 2;
    localparam int TRC      = 7;
    localparam int NREF     = 8;
    localparam int ADDR_W   = 12;
    localparam int P        = CLK_MHZ * PAUSE_US;
    localparam int T_PRE    = P;
    localparam int T_MRS    = P + TRP;
    localparam int T_REF0   = P + TRP + TRSC;
    localparam int T_RDY    = T_REF0 + NREF * TRC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] mode_word = '0;
    logic cs_n, ras_n, cas_n, we_n, cke, rdy;
    logic [1:0] dqm, ba;
    logic [ADDR_W-1:0] addr;

    int errors = 0;
    int checks = 0;

    always #(CLK_P/2) clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .TRP(TRP), .TRSC(TRSC),
        .TRC(TRC), .NREF(NREF), .ADDR_W(ADDR_W)
    ) uut (
        .clk(clk), .rst(rst), .mode_word(mode_word),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_cke(cke), .sd_dqm(dqm), .sd_ba(ba), .sd_addr(addr), .init_done(rdy)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pins_now();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    // R1: reset state
    task automatic test_reset_state();
        @(negedge clk); rst = 1'b1; mode_word = 12'hFFF;
        repeat (2) @(negedge clk);
        #1;
        check("R1", "pins", {28'd0, pins_now()}, 32'h7);
        check("R1", "cke", {31'd0, cke}, 32'd0);
        check("R1", "dqm", {30'd0, dqm}, 32'd3);
        check("R1", "ba/addr", {18'd0, ba, addr}, 32'd0);
        check("R1", "ready", {31'd0, rdy}, 32'd0);
    endtask

    // Runs a sequence from reset release; stops early at abort_at (if >= 0)
    task automatic run_sequence(input logic [ADDR_W-1:0] mval, input int abort_at);
        int last;
        last = (abort_at >= 0) ? abort_at : T_RDY + 6;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k <= last; k++) begin
            logic [3:0] exp_pins;
            logic [ADDR_W-1:0] exp_addr;
            string req;
            if (k > 0) @(negedge clk);
            mode_word = (k == T_MRS) ? mval : ADDR_W'(k * 37 + 12'h5A5);
            #1;
            exp_pins = 4'b0111;
            exp_addr = '0;
            req = (k < P) ? "R2" : "R6";
            if (k == T_PRE) begin
                exp_pins = 4'b0010; exp_addr = 12'h400; req = "R3";
            end else if (k == T_MRS) begin
                exp_pins = 4'b0000; exp_addr = mval; req = "R4";
            end else if (k >= T_REF0 && k < T_RDY && ((k - T_REF0) % TRC) == 0) begin
                exp_pins = 4'b0001; req = "R5";
            end
            check(req, $sformatf("pins@%0d", k), {28'd0, pins_now()}, {28'd0, exp_pins});
            check((k == T_MRS) ? "R4" : req, $sformatf("addr@%0d", k),
                  {18'd0, ba, addr}, {20'd0, exp_addr});
            if (k >= 1) check("R2", $sformatf("cke@%0d", k), {31'd0, cke}, 32'd1);
            check("R7", $sformatf("ready@%0d", k), {31'd0, rdy}, {31'd0, (k >= T_RDY)});
            check("R7", $sformatf("dqm@%0d", k), {30'd0, dqm}, (k >= T_RDY) ? 32'd0 : 32'd3);
        end
    endtask

    task automatic test_full_a();   run_sequence(12'h037, -1); endtask
    task automatic test_full_b();   run_sequence(12'hA2C, -1); endtask
    // R8: abort in the refresh train, then a full rerun must match
    task automatic test_restart();
        run_sequence(12'h111, T_REF0 + 3 * TRC + 2);
        run_sequence(12'h222, -1);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        test_reset_state();
        test_full_a();
        test_full_b();
        test_restart();
        test_reset_state();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule